// File: doc/BRIEF.md
# Partitioned Ternary Flow-Match Table

This block is a value/mask match table for receive flow steering. One physical table of entries is shared by several station interfaces. Each interface owns a slice of consecutive entries. A privileged controller sets the slice size of each interface through a configuration port. The slices are packed in interface order with no gaps: interface 0 starts at entry 0, and each later interface starts right after the last entry of the one before it.

Software loads each entry through an indexed write port. An entry holds a valid flag, a match value, a care mask and a result word. The write index is the physical entry number, from 0 to capacity minus 1. A search port takes a packet key and the number of the requesting interface. It reports hit or miss, the winning entry index and that entry's result word. Only entries inside the requester's slice can match, and among those the lowest index wins.

The entries hold no defined value after reset, so every slice must be cleared before use. A clear command walks every entry of one interface's slice and writes each one invalid, with its value and mask set to zero. The controller is a two-state machine. In ST_IDLE the write and search ports are open. The "clear launch" transition moves it from ST_IDLE to ST_CLEAR when a clear of a non-empty slice is requested. ST_CLEAR writes one entry per cycle. The "clear done" transition returns it to ST_IDLE after the last entry of the slice is written.

Top module: `flow_match_table`

## Requirements
- R1: After reset, res_valid, res_hit, cfg_err and clr_busy are 0, srch_ready and wr_ready are 1, and every slice size is 0, so every search misses.
- R2: An entry matches a key when its valid flag is 1 and ((key XOR value) AND mask) is zero. A mask bit of 1 means the key bit is compared.
- R3: When several entries in the requester's slice match, the lowest entry index is reported.
- R4: The slice of interface n covers entries from the sum of the sizes of interfaces 0..n-1, for its own size. Resizing one interface moves the slices of all later interfaces.
- R5: A search never reports an entry outside the slice of the interface given on srch_if.
- R6: A configuration write that would make the sum of all slice sizes exceed the capacity is rejected. The old sizes are kept, and cfg_err reads 1 from the next cycle. An accepted write sets cfg_err to 0.
- R7: A search accepted on a clock edge (srch_valid and srch_ready both 1) shows res_valid=1 with hit, index and result from that edge on, for one cycle. On a miss, res_idx and res_data are 0. res_valid is 0 in cycles with no accepted search.
- R8: clr_start with a non-empty slice puts the block in ST_CLEAR. clr_busy is 1 for exactly as many cycles as the slice has entries. Each entry in that slice is written invalid with zero value and mask. Entries outside the slice are untouched.
- R9: While clr_busy is 1, srch_ready and wr_ready are 0, and a presented search produces no result.
- R10: An accepted entry write (wr_valid and wr_ready) takes effect for any search accepted on the following edge or later.
- R11: An entry written with its valid flag 0 never matches, even with an all-zero mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Slice size write strobe |
| cfg_if | input | IFW | Interface whose slice size is written |
| cfg_count | input | CNT_W | New slice size in entries |
| cfg_err | output | 1 | Last configuration write was rejected |
| wr_valid | input | 1 | Entry write request |
| wr_ready | output | 1 | Entry write accepted this cycle |
| wr_idx | input | IDX_W | Physical entry index |
| wr_entry_valid | input | 1 | Valid flag to store |
| wr_key | input | KEY_W | Match value to store |
| wr_mask | input | KEY_W | Care mask to store |
| wr_result | input | RES_W | Result word to store |
| clr_start | input | 1 | Start clearing one interface's slice |
| clr_if | input | IFW | Interface whose slice is cleared |
| clr_busy | output | 1 | Clear walk in progress |
| srch_valid | input | 1 | Search request |
| srch_ready | output | 1 | Search accepted this cycle |
| srch_if | input | IFW | Requesting interface |
| srch_key | input | KEY_W | Packet key to look up |
| res_valid | output | 1 | Search result present |
| res_hit | output | 1 | An entry matched |
| res_idx | output | IDX_W | Winning entry index |
| res_data | output | RES_W | Winning entry result word |

## Verification
A search result sits in a register one edge behind acceptance. The bench raises srch_valid on a falling edge and reads res_* on the next falling edge, then confirms that res_valid is gone one cycle later. A configuration write reaches cfg_err after the same single edge, and an entry write is visible to a search accepted on the next edge. Back-to-back write-then-search tasks rely on that spacing. During a clear, the bench counts falling edges with clr_busy high against the slice size. It also keeps a search pending on every one of those edges and checks that no result appears.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CLEAR = 1'b1
    } fmt_state_e;

endpackage

// File: rtl/fmt_partition.sv
module fmt_partition #(
    parameter  int ENTRIES = 64,
    parameter  int NUM_IF  = 4,
    localparam int IFW     = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
    localparam int CNT_W   = $clog2(ENTRIES + 1),
    localparam int SUM_W   = $clog2(ENTRIES * NUM_IF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [IFW-1:0]   cfg_if,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             cfg_err,
    input  logic [IFW-1:0]   srch_if,
    output logic [CNT_W-1:0] srch_lo,
    output logic [CNT_W-1:0] srch_hi,
    input  logic [IFW-1:0]   clr_if,
    output logic [CNT_W-1:0] clr_lo,
    output logic [CNT_W-1:0] clr_hi,
    output logic [SUM_W-1:0] total
);

    logic [CNT_W-1:0] size_q [NUM_IF];
    logic [CNT_W-1:0] start  [NUM_IF];
    logic [SUM_W-1:0] cand_total;
    logic             cand_fits;
    logic             err_q;

    // Slice starts: each is the sum of the sizes of all earlier interfaces.
    always_comb begin
        for (int i = 0; i < NUM_IF; i++) begin
            logic [SUM_W-1:0] acc;
            acc = '0;
            for (int j = 0; j < i; j++) begin
                acc = acc + SUM_W'(size_q[j]);
            end
            start[i] = CNT_W'(acc);
        end
    end

    // Sum of all slice sizes if the pending write were accepted.
    always_comb begin
        cand_total = '0;
        for (int k = 0; k < NUM_IF; k++) begin
            if (IFW'(k) == cfg_if) begin
                cand_total = cand_total + SUM_W'(cfg_count);
            end else begin
                cand_total = cand_total + SUM_W'(size_q[k]);
            end
        end
        cand_fits = (cand_total <= SUM_W'(ENTRIES));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IF; i++) begin
                size_q[i] <= '0;
            end
            err_q <= 1'b0;
        end else if (cfg_valid) begin
            err_q <= !cand_fits;
            if (cand_fits) begin
                size_q[cfg_if] <= cfg_count;
            end
        end
    end

    assign cfg_err = err_q;
    assign srch_lo = start[srch_if];
    assign srch_hi = start[srch_if] + size_q[srch_if];
    assign clr_lo  = start[clr_if];
    assign clr_hi  = start[clr_if] + size_q[clr_if];
    assign total   = SUM_W'(start[NUM_IF-1]) + SUM_W'(size_q[NUM_IF-1]);

endmodule

// File: rtl/fmt_entry_array.sv
module fmt_entry_array #(
    parameter  int ENTRIES = 64,
    parameter  int KEY_W   = 32,
    parameter  int RES_W   = 32,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   widx,
    input  logic               wvalid,
    input  logic [KEY_W-1:0]   wkey,
    input  logic [KEY_W-1:0]   wmask,
    input  logic [RES_W-1:0]   wres,
    input  logic [KEY_W-1:0]   skey,
    input  logic [CNT_W-1:0]   lo,
    input  logic [CNT_W-1:0]   hi,
    output logic [ENTRIES-1:0] hits,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [RES_W-1:0]   rd_res
);

    // Storage deliberately has no reset: a slice must be cleared by command.
    logic [ENTRIES-1:0] vld_q;
    logic [KEY_W-1:0]   val_q [ENTRIES];
    logic [KEY_W-1:0]   msk_q [ENTRIES];
    logic [RES_W-1:0]   res_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            vld_q[widx] <= wvalid;
            val_q[widx] <= wkey;
            msk_q[widx] <= wmask;
            res_q[widx] <= wres;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic care_eq;
        logic in_slice;
        assign care_eq  = (((skey ^ val_q[g]) & msk_q[g]) == '0);
        assign in_slice = (CNT_W'(g) >= lo) && (CNT_W'(g) < hi);
        assign hits[g]  = vld_q[g] && care_eq && in_slice;
    end

    assign rd_res = res_q[rd_idx];

endmodule

// File: rtl/fmt_lowest_pick.sv
module fmt_lowest_pick #(
    parameter  int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest requesting index is assigned last.
    always_comb begin
        idx   = '0;
        found = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/flow_match_table.sv
module flow_match_table
    import fmt_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int NUM_IF  = 4,
    parameter  int KEY_W   = 32,
    parameter  int RES_W   = 32,
    localparam int IFW     = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int CNT_W   = $clog2(ENTRIES + 1),
    localparam int SUM_W   = $clog2(ENTRIES * NUM_IF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [IFW-1:0]   cfg_if,
    input  logic [CNT_W-1:0] cfg_count,
    output logic             cfg_err,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_entry_valid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [RES_W-1:0] wr_result,
    input  logic             clr_start,
    input  logic [IFW-1:0]   clr_if,
    output logic             clr_busy,
    input  logic             srch_valid,
    output logic             srch_ready,
    input  logic [IFW-1:0]   srch_if,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [RES_W-1:0] res_data
);

    fmt_state_e       state_q, state_d;
    logic [CNT_W-1:0] ptr_q, ptr_d;
    logic [CNT_W-1:0] end_q, end_d;

    logic [CNT_W-1:0] srch_lo, srch_hi, clr_lo, clr_hi;
    logic [SUM_W-1:0] total;

    logic             arr_we;
    logic [IDX_W-1:0] arr_widx;
    logic             arr_wvalid;
    logic [KEY_W-1:0] arr_wkey, arr_wmask;
    logic [RES_W-1:0] arr_wres;

    logic [ENTRIES-1:0] hits;
    logic               found;
    logic [IDX_W-1:0]   pick_idx;
    logic [RES_W-1:0]   pick_res;
    logic               accept;

    fmt_partition #(.ENTRIES(ENTRIES), .NUM_IF(NUM_IF)) u_part (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_if    (cfg_if),
        .cfg_count (cfg_count),
        .cfg_err   (cfg_err),
        .srch_if   (srch_if),
        .srch_lo   (srch_lo),
        .srch_hi   (srch_hi),
        .clr_if    (clr_if),
        .clr_lo    (clr_lo),
        .clr_hi    (clr_hi),
        .total     (total)
    );

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            end_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            end_q   <= end_d;
        end
    end

    // Next-state process.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        end_d   = end_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr_start && (clr_hi != clr_lo)) begin
                    state_d = ST_CLEAR;
                    ptr_d   = clr_lo;
                    end_d   = clr_hi;
                end
            end
            ST_CLEAR: begin
                ptr_d = ptr_q + CNT_W'(1);
                if ((ptr_q + CNT_W'(1)) == end_q) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process: port handshakes and entry write selection.
    always_comb begin
        wr_ready   = 1'b0;
        srch_ready = 1'b0;
        clr_busy   = 1'b0;
        arr_we     = 1'b0;
        arr_widx   = wr_idx;
        arr_wvalid = wr_entry_valid;
        arr_wkey   = wr_key;
        arr_wmask  = wr_mask;
        arr_wres   = wr_result;
        unique case (state_q)
            ST_IDLE: begin
                wr_ready   = 1'b1;
                srch_ready = 1'b1;
                arr_we     = wr_valid;
            end
            ST_CLEAR: begin
                clr_busy   = 1'b1;
                arr_we     = 1'b1;
                arr_widx   = ptr_q[IDX_W-1:0];
                arr_wvalid = 1'b0;
                arr_wkey   = '0;
                arr_wmask  = '0;
                arr_wres   = '0;
            end
            default: ;
        endcase
    end

    fmt_entry_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) u_arr (
        .clk    (clk),
        .we     (arr_we),
        .widx   (arr_widx),
        .wvalid (arr_wvalid),
        .wkey   (arr_wkey),
        .wmask  (arr_wmask),
        .wres   (arr_wres),
        .skey   (srch_key),
        .lo     (srch_lo),
        .hi     (srch_hi),
        .hits   (hits),
        .rd_idx (pick_idx),
        .rd_res (pick_res)
    );

    fmt_lowest_pick #(.N(ENTRIES)) u_pick (
        .req   (hits),
        .found (found),
        .idx   (pick_idx)
    );

    assign accept = srch_valid && srch_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= accept;
            res_hit   <= accept && found;
            res_idx   <= (accept && found) ? pick_idx : '0;
            res_data  <= (accept && found) ? pick_res : '0;
        end
    end

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = 7,
    parameter int SUM_W   = 9,
    parameter int RES_W   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_valid,
    input logic             srch_ready,
    input logic             wr_ready,
    input logic             clr_start,
    input logic             clr_busy,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [RES_W-1:0] res_data,
    input logic [CNT_W-1:0] srch_lo,
    input logic [CNT_W-1:0] srch_hi,
    input logic [SUM_W-1:0] total
);

    AST_RES_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_valid && srch_ready) |=> res_valid); // R7

    AST_RES_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(srch_valid && srch_ready) |=> !res_valid); // R7

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0 && res_data == '0)); // R7

    AST_HIT_IN_OWN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |->
            ((CNT_W'(res_idx) >= $past(srch_lo)) && (CNT_W'(res_idx) < $past(srch_hi)))); // R5

    AST_TOTAL_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        total <= SUM_W'(ENTRIES)); // R6

    AST_CLEAR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_busy) |-> $past(clr_start)); // R8

    AST_CLEAR_BLOCKS_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |-> (!srch_ready && !wr_ready)); // R9

    AST_CLEAR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && srch_valid) |=> !res_valid); // R9

endmodule

bind flow_match_table fmt_checker #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W),
    .SUM_W   (SUM_W),
    .RES_W   (RES_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_valid (srch_valid),
    .srch_ready (srch_ready),
    .wr_ready   (wr_ready),
    .clr_start  (clr_start),
    .clr_busy   (clr_busy),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx),
    .res_data   (res_data),
    .srch_lo    (srch_lo),
    .srch_hi    (srch_hi),
    .total      (total)
);

// File: tb/tb_flow_match_table.sv
module tb_flow_match_table;

    localparam int ENTRIES = 64;
    localparam int NUM_IF  = 4;
    localparam int IFW     = 2;
    localparam int IDX_W   = 6;
    localparam int CNT_W   = 7;
    localparam int VW      = IFW + 32 + 1 + IDX_W + 32;
    localparam int NV      = 10;

    // {interface, key, expect hit, expect index, expect result}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 32'h0000_00AA, 1'b1, 6'd3,  32'h0000_1003},  // R3 lowest of 3,5
        {2'd0, 32'h0000_00BB, 1'b1, 6'd5,  32'h0000_1005},  // R2 wildcard
        {2'd0, 32'h1234_5678, 1'b1, 6'd5,  32'h0000_1005},  // R11 idx2 invalid
        {2'd1, 32'h1234_5678, 1'b1, 6'd17, 32'h0000_2011},  // R3 17 over 20
        {2'd1, 32'h1234_FFFF, 1'b1, 6'd17, 32'h0000_2011},  // R2 masked bits
        {2'd1, 32'h9999_0000, 1'b0, 6'd0,  32'h0000_0000},  // R7 miss
        {2'd2, 32'hDEAD_BEEF, 1'b1, 6'd30, 32'h0000_301E},  // R2 exact
        {2'd2, 32'h0000_0001, 1'b1, 6'd47, 32'h0000_302F},  // R4 last of slice
        {2'd3, 32'hDEAD_BEEF, 1'b1, 6'd48, 32'h0000_4030},  // R5 not 30
        {2'd3, 32'h0000_00AA, 1'b0, 6'd0,  32'h0000_0000}   // R5 idx3 outside
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [IFW-1:0]   cfg_if = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic             cfg_err;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_entry_valid = 1'b0;
    logic [31:0]      wr_key = '0;
    logic [31:0]      wr_mask = '0;
    logic [31:0]      wr_result = '0;
    logic             clr_start = 1'b0;
    logic [IFW-1:0]   clr_if = '0;
    logic             clr_busy;
    logic             srch_valid = 1'b0;
    logic             srch_ready;
    logic [IFW-1:0]   srch_if = '0;
    logic [31:0]      srch_key = '0;
    logic             res_valid;
    logic             res_hit;
    logic [IDX_W-1:0] res_idx;
    logic [31:0]      res_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flow_match_table #(.ENTRIES(ENTRIES), .NUM_IF(NUM_IF), .KEY_W(32), .RES_W(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_if(cfg_if), .cfg_count(cfg_count), .cfg_err(cfg_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx),
        .wr_entry_valid(wr_entry_valid), .wr_key(wr_key), .wr_mask(wr_mask),
        .wr_result(wr_result),
        .clr_start(clr_start), .clr_if(clr_if), .clr_busy(clr_busy),
        .srch_valid(srch_valid), .srch_ready(srch_ready), .srch_if(srch_if),
        .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_data(res_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_count(input int ifn, input int cnt);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_if    = IFW'(ifn);
        cfg_count = CNT_W'(cnt);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic write_entry(input int idx, input logic v, input logic [31:0] k,
                               input logic [31:0] m, input logic [31:0] r);
        @(negedge clk);
        wr_valid       = 1'b1;
        wr_idx         = IDX_W'(idx);
        wr_entry_valid = v;
        wr_key         = k;
        wr_mask        = m;
        wr_result      = r;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic search(input string tag, input int ifn, input logic [31:0] k,
                          input logic eh, input int ei, input logic [31:0] ed);
        @(negedge clk);
        srch_valid = 1'b1;
        srch_if    = IFW'(ifn);
        srch_key   = k;
        chk({tag, " srch_ready"}, 32'(srch_ready), 32'd1);
        @(negedge clk);
        srch_valid = 1'b0;
        chk({tag, " res_valid"}, 32'(res_valid), 32'd1);
        chk({tag, " res_hit"},   32'(res_hit),   32'(eh));
        chk({tag, " res_idx"},   32'(res_idx),   32'(ei));
        chk({tag, " res_data"},  res_data,       ed);
        @(negedge clk);
        chk({tag, " res_valid drops"}, 32'(res_valid), 32'd0);
    endtask

    task automatic run_clear(input string tag, input int ifn, input int exp_cycles);
        int n;
        @(negedge clk);
        clr_start = 1'b1;
        clr_if    = IFW'(ifn);
        @(negedge clk);
        clr_start = 1'b0;
        n = 0;
        while (clr_busy) begin
            n++;
            if (srch_ready !== 1'b0 || wr_ready !== 1'b0 || res_valid !== 1'b0) begin
                chk({tag, " R9 ports closed"},
                    {29'd0, srch_ready, wr_ready, res_valid}, 32'd0);
            end
            srch_valid = 1'b1;
            srch_if    = IFW'(ifn);
            srch_key   = 32'h1234_5678;
            @(negedge clk);
        end
        srch_valid = 1'b0;
        chk({tag, " R8 busy cycles"}, 32'(n), 32'(exp_cycles));
        chk({tag, " R9 no result while busy"}, 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 res_valid",  32'(res_valid),  32'd0);
        chk("R1 cfg_err",    32'(cfg_err),    32'd0);
        chk("R1 clr_busy",   32'(clr_busy),   32'd0);
        chk("R1 srch_ready", 32'(srch_ready), 32'd1);
        chk("R1 wr_ready",   32'(wr_ready),   32'd1);
        search("R1 empty slices miss", 0, 32'h0, 1'b0, 0, 32'h0);

        // Partition: 16, 8, 24, 16 -> starts 0, 16, 24, 48 (R4)
        set_count(0, 16);
        set_count(1, 8);
        set_count(2, 24);
        set_count(3, 16);
        chk("R6 full fit accepted", 32'(cfg_err), 32'd0);

        run_clear("R8 if0", 0, 16);
        run_clear("R8 if1", 1, 8);
        run_clear("R8 if2", 2, 24);
        run_clear("R8 if3", 3, 16);

        write_entry(3,  1'b1, 32'h0000_00AA, 32'h0000_00FF, 32'h0000_1003);
        write_entry(5,  1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_1005);
        write_entry(2,  1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_1002);
        write_entry(17, 1'b1, 32'h1234_0000, 32'hFFFF_0000, 32'h0000_2011);
        write_entry(20, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_2014);
        write_entry(30, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_301E);
        write_entry(47, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_302F);
        write_entry(48, 1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0000_4030);

        for (int v = 0; v < NV; v++) begin
            search($sformatf("R2/R3/R5 vector %0d", v),
                   int'(VEC[v][VW-1 -: IFW]),
                   VEC[v][VW-IFW-1 -: 32],
                   VEC[v][IDX_W+32],
                   int'(VEC[v][IDX_W+31 -: IDX_W]),
                   VEC[v][31:0]);
        end

        // R6 overflow rejected, old sizes kept
        set_count(3, 17);
        chk("R6 overflow flagged", 32'(cfg_err), 32'd1);
        search("R6 if3 slice kept", 3, 32'hDEAD_BEEF, 1'b1, 48, 32'h0000_4030);
        search("R6 if2 slice kept", 2, 32'h0000_0001, 1'b1, 47, 32'h0000_302F);
        set_count(3, 16);
        chk("R6 accepted clears flag", 32'(cfg_err), 32'd0);

        // R4 shrinking if1 to 0 moves if2 to 16..39
        set_count(1, 0);
        search("R4 if2 moved down", 2, 32'h1234_5678, 1'b1, 17, 32'h0000_2011);
        search("R4 if2 end moved", 2, 32'h0000_0001, 1'b0, 0, 32'h0);
        set_count(1, 8);

        // R8 clear of if1 leaves other slices alone
        run_clear("R8 if1 again", 1, 8);
        search("R8 if1 cleared", 1, 32'h1234_5678, 1'b0, 0, 32'h0);
        search("R8 if0 untouched", 0, 32'h0000_00AA, 1'b1, 3, 32'h0000_1003);
        search("R8 if2 untouched", 2, 32'hDEAD_BEEF, 1'b1, 30, 32'h0000_301E);

        // R10 write visible to the very next search
        write_entry(19, 1'b1, 32'h5555_0000, 32'hFFFF_0000, 32'h0000_2013);
        search("R10 write then search", 1, 32'h5555_1234, 1'b1, 19, 32'h0000_2013);

        // R11 invalid entry with zero mask inside its slice
        write_entry(16, 1'b0, 32'h0, 32'h0, 32'h0000_2010);
        search("R11 invalid never matches", 1, 32'h5555_0000, 1'b1, 19, 32'h0000_2013);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule